// File: doc/BRIEF.md
# Tag-matching reservation station array

This block holds the waiting operations for one class of functional unit in an out-of-order core that renames its sources to producer tags. An operation enters through an issue stream. For each of its two sources it carries either a value or the tag of the station that will produce the value. Each occupied entry watches one result broadcast bus (`cdb_*`). When the bus carries the tag an operand is waiting on, that operand takes the bus data. An entry whose two operands are both present is offered to the functional unit through a dispatch stream. Each station has its own tag, equal to `TAG_BASE` plus its index. A station stays occupied while its operation runs. It becomes free when its own tag appears on the bus, which means its result has been written.

Both streams use valid/ready. An issue transfer happens in a cycle where `issue_valid` and `issue_ready` are both high. `issue_ready` is high whenever at least one entry is free. When every entry is occupied, issue stalls and `issue_ready` stays low. A dispatch transfer happens in a cycle where `disp_valid` and `disp_ready` are both high. While the unit holds `disp_ready` low, the offered entry and every field of it stay unchanged. The bus and `flush` are plain control inputs that have no handshake.

Top module: `rs_array`

## Requirements
- R1: After reset every entry is free: `issue_ready` is 1 and `disp_valid` is 0.
- R2: An accepted issue goes into the lowest-index free entry. `issue_ready` is 0 exactly when all `NUM_RS` entries are occupied, and an issue offered then is not accepted.
- R3: A source tag of 0 means the value field is valid; any nonzero tag means the operand is waiting for that producer. An entry issued with both tags 0 is offered for dispatch in the next cycle, with the issued op and values.
- R4: A waiting operand captures `cdb_data` only in a cycle where `cdb_valid` is 1 and `cdb_tag` equals its tag. A broadcast with any other tag leaves the entry waiting and its values unchanged.
- R5: A broadcast in the same cycle as the issue is forwarded. A source whose tag matches `cdb_tag` is stored as valid, with `cdb_data` as its value.
- R6: When several entries are ready, the lowest-index ready entry is offered, and at most one is dispatched per cycle. While `disp_valid` is 1 and `disp_ready` is 0, the same entry stays offered in the next cycle with all its fields unchanged, even if an entry with a lower index becomes ready.
- R7: `disp_tag` equals `TAG_BASE` plus the index of the offered entry (1 to 4 by default). A dispatched entry stays occupied until a broadcast carries its own tag, and it is free from the next cycle on.
- R8: When `flush` is 1, every entry is cleared by the next cycle, so `issue_ready` is 1 and `disp_valid` is 0. An issue or dispatch in the flush cycle has no effect.
- R9: An entry that has been dispatched is never offered again until it has been freed and issued anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries |
| issue_valid | input | 1 | Issue stream valid |
| issue_ready | output | 1 | A free entry exists |
| issue_op | input | OP_W | Operation code |
| issue_tag_a | input | TAG_W | Source A producer tag, 0 = value valid |
| issue_val_a | input | DATA_W | Source A value |
| issue_tag_b | input | TAG_W | Source B producer tag, 0 = value valid |
| issue_val_b | input | DATA_W | Source B value |
| cdb_valid | input | 1 | Broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcasting producer |
| cdb_data | input | DATA_W | Broadcast result |
| disp_valid | output | 1 | A ready entry is offered |
| disp_ready | input | 1 | Functional unit accepts |
| disp_op | output | OP_W | Offered operation |
| disp_val_a | output | DATA_W | Offered source A |
| disp_val_b | output | DATA_W | Offered source B |
| disp_tag | output | TAG_W | Tag of the offered station |

## Verification
If an operand takes data from the wrong tag, the wrong data appears on `disp_val_a`/`disp_val_b` in the first cycle that entry is offered. If an operand misses its tag, the entry is never offered, so `disp_valid` stays low where the reference model expects it high. A broken occupancy state shows as the wrong `issue_ready` in the next cycle, or as a `disp_tag` that is offered twice. Either one shows within one cycle of the event that caused it. A wrong priority or a broken hold under back-pressure shows at once as the wrong `disp_tag`.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_DEF_DATA_W = 64;
  localparam int RS_DEF_TAG_W  = 4;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              have,
  output logic [DATA_W-1:0] val
);
  logic [TAG_W-1:0] tag_q;
  logic             in_hit, q_hit;

  assign in_hit = (in_tag != '0) && cdb_valid && (cdb_tag == in_tag);
  assign q_hit  = (tag_q  != '0) && cdb_valid && (cdb_tag == tag_q);
  assign have   = (tag_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      val   <= '0;
    end else if (load) begin
      tag_q <= in_hit ? '0 : in_tag;
      val   <= in_hit ? cdb_data : in_val;
    end else if (q_hit) begin
      tag_q <= '0;
      val   <= cdb_data;
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int               OP_W   = 4,
  parameter int               DATA_W = 64,
  parameter int               TAG_W  = 4,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc,
  input  logic              take,
  input  logic [OP_W-1:0]   in_op,
  input  logic [TAG_W-1:0]  in_tag_a,
  input  logic [DATA_W-1:0] in_val_a,
  input  logic [TAG_W-1:0]  in_tag_b,
  input  logic [DATA_W-1:0] in_val_b,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] val_a,
  output logic [DATA_W-1:0] val_b
);
  rs_state_e st_q;
  logic [1:0] have;
  logic [1:0][TAG_W-1:0]  src_tag;
  logic [1:0][DATA_W-1:0] src_val, got_val;

  assign src_tag = {in_tag_b, in_tag_a};
  assign src_val = {in_val_b, in_val_a};

  for (genvar k = 0; k < 2; k++) begin : g_src
    rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd (
      .clk(clk), .rst_n(rst_n), .load(alloc),
      .in_tag(src_tag[k]), .in_val(src_val[k]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .have(have[k]), .val(got_val[k])
    );
  end

  assign val_a = got_val[0];
  assign val_b = got_val[1];
  assign busy  = (st_q != ST_FREE);
  assign ready = (st_q == ST_WAIT) && (&have);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      st_q <= ST_FREE;
    end else begin
      case (st_q)
        ST_FREE: if (alloc) st_q <= ST_WAIT;
        ST_WAIT: if (take) st_q <= ST_EXEC;
        ST_EXEC: if (cdb_valid && cdb_tag == MY_TAG) st_q <= ST_FREE;
        default: st_q <= ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) op <= '0;
    else if (alloc) op <= in_op;
  end
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = IDX_W'(i);
        onehot = N'(1) << i;
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 4,
  parameter int OP_W     = 4,
  parameter int DATA_W   = RS_DEF_DATA_W,
  parameter int TAG_W    = RS_DEF_TAG_W,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [TAG_W-1:0]  issue_tag_a,
  input  logic [DATA_W-1:0] issue_val_a,
  input  logic [TAG_W-1:0]  issue_tag_b,
  input  logic [DATA_W-1:0] issue_val_b,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_val_a,
  output logic [DATA_W-1:0] disp_val_b,
  output logic [TAG_W-1:0]  disp_tag
);
  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  logic [NUM_RS-1:0] busy, rdy, free_oh, rdy_oh, alloc, take;
  logic [NUM_RS-1:0][OP_W-1:0]   e_op;
  logic [NUM_RS-1:0][DATA_W-1:0] e_va, e_vb;
  logic [IDX_W-1:0] free_idx, rdy_idx, sel_idx, held_idx_q;
  logic rdy_any, hold_q, issue_fire, disp_fire;

  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_pick_free (
    .req(~busy), .any(issue_ready), .idx(free_idx), .onehot(free_oh)
  );

  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_pick_rdy (
    .req(rdy), .any(rdy_any), .idx(rdy_idx), .onehot(rdy_oh)
  );

  assign issue_fire = issue_valid && issue_ready;
  assign sel_idx    = hold_q ? held_idx_q : rdy_idx;
  assign disp_valid = rdy[sel_idx];
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_op    = e_op[sel_idx];
  assign disp_val_a = e_va[sel_idx];
  assign disp_val_b = e_vb[sel_idx];
  assign disp_tag   = TAG_W'(TAG_BASE) + TAG_W'(sel_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      held_idx_q <= '0;
    end else begin
      hold_q     <= !flush && disp_valid && !disp_ready;
      held_idx_q <= sel_idx;
    end
  end

  for (genvar i = 0; i < NUM_RS; i++) begin : g_ent
    assign alloc[i] = issue_fire && free_oh[i];
    assign take[i]  = disp_fire && (sel_idx == IDX_W'(i));

    rs_entry #(
      .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
      .MY_TAG(TAG_W'(TAG_BASE + i))
    ) u_ent (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc(alloc[i]), .take(take[i]),
      .in_op(issue_op),
      .in_tag_a(issue_tag_a), .in_val_a(issue_val_a),
      .in_tag_b(issue_tag_b), .in_val_b(issue_val_b),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .busy(busy[i]), .ready(rdy[i]),
      .op(e_op[i]), .val_a(e_va[i]), .val_b(e_vb[i])
    );
  end
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int OP_W   = 4,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [TAG_W-1:0]  issue_tag_a,
  input logic [TAG_W-1:0]  issue_tag_b,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [OP_W-1:0]   disp_op,
  input logic [DATA_W-1:0] disp_val_a,
  input logic [DATA_W-1:0] disp_val_b,
  input logic [TAG_W-1:0]  disp_tag
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (issue_ready && !disp_valid));

  assert_ready_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !flush && !disp_valid &&
     issue_tag_a == '0 && issue_tag_b == '0) |=> disp_valid);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready && !flush) |=>
      (disp_valid && $stable(disp_tag) && $stable(disp_op) &&
       $stable(disp_val_a) && $stable(disp_val_b)));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (issue_ready && !disp_valid));

  assert_no_redispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !flush) |=>
      !(disp_valid && disp_tag == $past(disp_tag)));
endmodule

bind rs_array rs_array_chk #(.OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .issue_valid(issue_valid), .issue_ready(issue_ready),
  .issue_tag_a(issue_tag_a), .issue_tag_b(issue_tag_b),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
  .disp_val_a(disp_val_a), .disp_val_b(disp_val_b), .disp_tag(disp_tag)
);

// File: tb/rs_array_test.sv
`timescale 1ns/1ps
module rs_array_test;
  localparam int N = 4;
  localparam int TB = 1;

  logic clk = 0, rst_n = 0, flush = 0;
  logic issue_valid = 0, issue_ready;
  logic [3:0]  issue_op = 0, issue_tag_a = 0, issue_tag_b = 0;
  logic [63:0] issue_val_a = 0, issue_val_b = 0;
  logic cdb_valid = 0;
  logic [3:0]  cdb_tag = 0;
  logic [63:0] cdb_data = 0;
  logic disp_valid, disp_ready = 1;
  logic [3:0]  disp_op, disp_tag;
  logic [63:0] disp_val_a, disp_val_b;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rs_array uut (.*);

  bit          m_val[N], m_dis[N];
  logic [3:0]  m_op[N], m_ta[N], m_tb[N];
  logic [63:0] m_va[N], m_vb[N];
  bit m_hold;
  int m_hidx;

  function automatic int m_sel();
    if (m_hold) return m_hidx;
    for (int i = 0; i < N; i++)
      if (m_val[i] && !m_dis[i] && m_ta[i] == 0 && m_tb[i] == 0) return i;
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    return -1;
  endfunction

  function automatic bit hit(logic [3:0] t);
    return t != 0 && cdb_valid && cdb_tag == t;
  endfunction

  task automatic fail(string req, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic compare(string req);
    int s = m_sel();
    bit ir = (m_free() >= 0);
    vectors++;
    if (issue_ready !== ir) fail(req, "issue_ready", 64'(issue_ready), 64'(ir));
    if (disp_valid !== (s >= 0)) fail(req, "disp_valid", 64'(disp_valid), 64'(s >= 0));
    else if (s >= 0) begin
      if (disp_tag !== 4'(TB + s)) fail(req, "disp_tag", 64'(disp_tag), 64'(TB + s));
      if (disp_op !== m_op[s]) fail(req, "disp_op", 64'(disp_op), 64'(m_op[s]));
      if (disp_val_a !== m_va[s]) fail(req, "disp_val_a", disp_val_a, m_va[s]);
      if (disp_val_b !== m_vb[s]) fail(req, "disp_val_b", disp_val_b, m_vb[s]);
    end
  endtask

  task automatic model_step();
    int s = m_sel();
    int f = m_free();
    if (flush) begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_dis[i] = 0; end
      m_hold = 0;
      return;
    end
    m_hold = (s >= 0) && !disp_ready;
    m_hidx = s;
    for (int i = 0; i < N; i++) begin
      if (m_val[i]) begin
        if (hit(m_ta[i])) begin m_ta[i] = 0; m_va[i] = cdb_data; end
        if (hit(m_tb[i])) begin m_tb[i] = 0; m_vb[i] = cdb_data; end
        if (m_dis[i] && cdb_valid && cdb_tag == 4'(TB + i)) m_val[i] = 0;
        if (s == i && disp_ready) m_dis[i] = 1;
      end
    end
    if (issue_valid && f >= 0) begin
      m_val[f] = 1; m_dis[f] = 0; m_op[f] = issue_op;
      m_ta[f] = hit(issue_tag_a) ? 4'd0 : issue_tag_a;
      m_va[f] = hit(issue_tag_a) ? cdb_data : issue_val_a;
      m_tb[f] = hit(issue_tag_b) ? 4'd0 : issue_tag_b;
      m_vb[f] = hit(issue_tag_b) ? cdb_data : issue_val_b;
    end
  endtask

  task automatic step(string req);
    compare(req);
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    issue_valid = 0; cdb_valid = 0; flush = 0; disp_ready = 1;
  endtask

  task automatic iss(logic [3:0] op, logic [3:0] ta, logic [63:0] va,
                     logic [3:0] tb, logic [63:0] vb);
    issue_valid = 1; issue_op = op;
    issue_tag_a = ta; issue_val_a = va; issue_tag_b = tb; issue_val_b = vb;
  endtask

  task automatic bcast(logic [3:0] t, logic [63:0] d);
    cdb_valid = 1; cdb_tag = t; cdb_data = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_dis[i] = 0; m_op[i] = 0;
      m_ta[i] = 0; m_tb[i] = 0; m_va[i] = 0; m_vb[i] = 0;
    end
    m_hold = 0; m_hidx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    step("R1");
    // R3: both sources valid at issue, offered next cycle
    iss(4'h3, 0, 64'h1111, 0, 64'h2222); step("R3");
    idle(); step("R3");
    step("R7");
    // R7: free slot 0 by its own tag
    bcast(4'd1, 64'h0); step("R7");
    idle(); step("R7");
    // R4: wrong tag ignored, matching tag captured
    iss(4'h5, 4'd9, 64'h0, 0, 64'hbbbb); step("R4");
    idle(); bcast(4'd10, 64'hdead); step("R4");
    idle(); step("R4");
    bcast(4'd9, 64'hc0de); step("R4");
    idle(); step("R4");
    // R5: forwarding at issue
    bcast(4'd12, 64'hf00d); iss(4'h6, 4'd12, 64'h0, 4'd12, 64'h0); step("R5");
    idle(); step("R5");
    // R2: fill everything with waiting entries
    flush = 1; step("R8");
    idle();
    for (int i = 0; i < N + 2; i++) begin
      iss(4'(i), 4'd13, 64'(i), 4'd14, 64'(i)); step("R2");
    end
    idle(); step("R2");
    // R6: all ready at once, back-pressure holds lowest
    bcast(4'd13, 64'haaaa); step("R6");
    disp_ready = 0; bcast(4'd14, 64'hcccc); step("R6");
    cdb_valid = 0; step("R6");
    disp_ready = 1; step("R6");
    step("R9"); step("R9"); step("R9");
    // R8: flush while busy
    flush = 1; iss(4'h1, 0, 64'h1, 0, 64'h2); step("R8");
    idle(); step("R8");
    // random phase
    for (int c = 0; c < 4000; c++) begin
      issue_valid = ($urandom % 10) < 6;
      issue_op = 4'($urandom);
      issue_tag_a = ($urandom % 2) ? 4'd0 : 4'($urandom);
      issue_tag_b = ($urandom % 2) ? 4'd0 : 4'($urandom);
      issue_val_a = {$urandom, $urandom};
      issue_val_b = {$urandom, $urandom};
      cdb_valid = ($urandom % 10) < 6;
      cdb_tag = ($urandom % 2) ? 4'(1 + $urandom % 4) : 4'($urandom);
      cdb_data = {$urandom, $urandom};
      disp_ready = ($urandom % 10) < 7;
      flush = ($urandom % 100) == 0;
      step("R6 R9");
    end
    idle(); step("R1");
    finish_run();
  end
endmodule